// File: doc/BRIEF.md
# Tile-Map Display Fetcher

This block produces the active-video pixel stream of a character-cell display. The screen is not stored as a bitmap. It is described by a map of tile entries, 80 columns by 60 rows of 8x8-pixel tiles, which covers 640x480 pixels. Each entry takes two bytes, so a full screen of map data is 9600 bytes. The two bytes of an entry form a shape index. The index points into a separate shape memory that holds one byte per tile row, with one bit per pixel. The block walks the map in raster order and reads the map bytes and then the shape byte for every tile. It expands each shape bit into a foreground or background colour.

The map memory sits outside the block on a single port with one cycle of read latency. The display fetch needs that port for only one cycle in every four, when it reads one map byte per four pixels. A processor-side write port shares the map memory through the block and is served in the three remaining cycles. Software can therefore repaint any 8x8 area with one or two byte writes while the picture is being shown. Sync timing and the contents of the shape memory belong to other blocks. The block advances one pixel per clock and wraps at the end of each frame. Its output stream trails its fetch position by eight clocks.

Top module: `tile_map_fetcher`

## Requirements
- R1: While reset is held and after it is released, pix_valid, map_we and cpu_done are low. pix_valid first rises in the eighth clock cycle after reset release, reporting pixel (0,0).
- R2: Once valid, the output delivers one pixel per clock in raster order. pix_x counts 0..H_PIX-1, then wraps to 0 as pix_y advances, and pix_y wraps after V_PIX-1. pix_valid never drops again.
- R3: With fetch position (x,y) counting pixels from reset release, a display map read (map_re high, map_we low) happens exactly when x mod 4 = 0. At x mod 8 = 0 it reads address 2*((y/8)*COLS + x/8), the low index byte. At x mod 8 = 4 it reads that address plus one, the high index byte. The map memory returns map_rdata in the cycle after map_re.
- R4: When x mod 8 = 6, shp_re is high and shp_addr = index*8 + (y mod 8). Here index = {high byte, low byte} of the current tile's entry. shp_rdata is expected in the following cycle.
- R5: Bit 7 of a shape byte is the leftmost pixel of the tile row. A set bit outputs fg_color and a clear bit outputs bg_color.
- R6: A pending CPU write drives map_we with cpu_addr and cpu_data in one clock. That clock only ever has x mod 4 not equal to 0, and map_we is never high without cpu_req.
- R7: cpu_done pulses high for exactly one cycle, in the cycle after the write. Each request produces exactly one write, even when cpu_req stays high through the done cycle.
- R8: A map byte written by the CPU appears in every frame whose fetch of that tile follows the write.
- R9: A change on fg_color or bg_color is reflected in pix_color from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fg_color | input | COLOR_W (8) | Colour for set shape bits |
| bg_color | input | COLOR_W (8) | Colour for clear shape bits |
| cpu_req | input | 1 | CPU write request, held until cpu_done |
| cpu_addr | input | MAP_AW (14) | Map byte address of the write |
| cpu_data | input | 8 | Byte to write |
| cpu_done | output | 1 | One-cycle write acknowledge |
| map_re | output | 1 | Map memory read strobe |
| map_we | output | 1 | Map memory write strobe |
| map_addr | output | MAP_AW (14) | Map memory address |
| map_wdata | output | 8 | Map memory write data |
| map_rdata | input | 8 | Map memory read data, one cycle after map_re |
| shp_re | output | 1 | Shape memory read strobe |
| shp_addr | output | 19 | Shape memory address |
| shp_rdata | input | 8 | Shape byte, one cycle after shp_re |
| pix_valid | output | 1 | Pixel output is valid |
| pix_x | output | XW (10) | Column of the output pixel |
| pix_y | output | YW (9) | Line of the output pixel |
| pix_color | output | COLOR_W (8) | Colour of the output pixel |

## Verification
A slip in the fetch position corrupts the map and shape addresses at once, in the same cycle. A wrong byte capture or a wrong shape index shows up within eight clocks, as wrong colours across a whole tile row. A stale or missing done mask shows up at the map port as a second map_we in the cycle after the first one. A slot arbitration error shows up as map_we on a display-read cycle. The bench compares every address strobe against its own count of cycles since reset. It compares entire frames against a shadow copy of the map, so a wrong pixel is reported with its coordinates no later than the end of the frame.

// File: rtl/tmf_pkg.sv
package tmf_pkg;
    // Tile edge is 2**TILE_LG pixels; entries carry a two-byte shape index.
    localparam int TILE_LG  = 3;
    localparam int TILE_PIX = 1 << TILE_LG;
    localparam int IDX_W    = 16;

    typedef logic [7:0] mbyte_t;
endpackage

// File: rtl/tmf_scan.sv
module tmf_scan
    import tmf_pkg::*;
#(
    parameter int H_PIX = 640,
    parameter int V_PIX = 480,
    parameter int XW    = $clog2(H_PIX),
    parameter int YW    = $clog2(V_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y
);
    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } scan_t;

    scan_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.x == XW'(H_PIX - 1)) begin
            pos_d.x = '0;
            if (pos_q.y == YW'(V_PIX - 1)) begin
                pos_d.y = '0;
            end else begin
                pos_d.y = pos_q.y + YW'(1);
            end
        end else begin
            pos_d.x = pos_q.x + XW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign x = pos_q.x;
    assign y = pos_q.y;

    // R2: the line changes only at the end of a line
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pos_q.x) != XW'(H_PIX - 1)) |-> $stable(pos_q.y)) // R2
        else $error("line advanced mid-line");
endmodule

// File: rtl/tmf_mapport.sv
module tmf_mapport
    import tmf_pkg::*;
#(
    parameter int COLS   = 80,
    parameter int XW     = 10,
    parameter int YW     = 9,
    parameter int MAP_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XW-1:0]     x,
    input  logic [YW-1:0]     y,
    input  logic              cpu_req,
    input  logic [MAP_AW-1:0] cpu_addr,
    input  mbyte_t            cpu_data,
    output logic              cpu_done,
    output logic              map_re,
    output logic              map_we,
    output logic [MAP_AW-1:0] map_addr,
    output mbyte_t            map_wdata
);
    // Display reads own the first cycle of every half tile.
    localparam int SLOT_LG = TILE_LG - 1;

    typedef struct packed {
        logic done;
    } port_t;

    port_t st_d, st_q;

    logic              disp_slot;
    logic              grant;
    int                tile_i;
    logic [MAP_AW-1:0] disp_addr;

    always_comb begin
        disp_slot = (x[SLOT_LG-1:0] == '0);
        tile_i    = (int'(y) / TILE_PIX) * COLS + (int'(x) / TILE_PIX);
        disp_addr = MAP_AW'(2 * tile_i + int'(x[TILE_LG-1]));
        // A request is masked in its own done cycle so it is written once.
        grant     = cpu_req && !disp_slot && !st_q.done;
        st_d.done = grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_re    = disp_slot;
    assign map_we    = grant;
    assign map_addr  = grant ? cpu_addr : disp_addr;
    assign map_wdata = cpu_data;
    assign cpu_done  = st_q.done;

    AST_DONE_FOLLOWS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> cpu_done) // R7
        else $error("write without acknowledge");

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done) // R7
        else $error("acknowledge longer than one cycle");

    AST_WE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> cpu_req) // R6
        else $error("write with no request");
endmodule

// File: rtl/tmf_pixel.sv
module tmf_pixel
    import tmf_pkg::*;
#(
    parameter int H_PIX   = 640,
    parameter int XW      = 10,
    parameter int YW      = 9,
    parameter int COLOR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [XW-1:0]             x,
    input  logic [YW-1:0]             y,
    input  mbyte_t                    map_rdata,
    input  mbyte_t                    shp_rdata,
    input  logic [COLOR_W-1:0]        fg_color,
    input  logic [COLOR_W-1:0]        bg_color,
    output logic                      shp_re,
    output logic [IDX_W+TILE_LG-1:0]  shp_addr,
    output logic                      pix_valid,
    output logic [XW-1:0]             pix_x,
    output logic [YW-1:0]             pix_y,
    output logic [COLOR_W-1:0]        pix_color
);
    localparam logic [TILE_LG-1:0] PH_LO   = TILE_LG'(1);
    localparam logic [TILE_LG-1:0] PH_HI   = TILE_LG'(TILE_PIX / 2 + 1);
    localparam logic [TILE_LG-1:0] PH_SHP  = TILE_LG'(TILE_PIX - 2);
    localparam logic [TILE_LG-1:0] PH_LOAD = TILE_LG'(TILE_PIX - 1);

    typedef struct packed {
        mbyte_t              lo;
        mbyte_t              hi;
        mbyte_t              sreg;
        logic                valid;
        logic [XW-1:0]       px;
        logic [YW-1:0]       py;
        logic [COLOR_W-1:0]  color;
    } pix_t;

    pix_t st_d, st_q;
    logic [TILE_LG-1:0] phase;

    always_comb begin
        st_d  = st_q;
        phase = x[TILE_LG-1:0];
        if (phase == PH_LO) begin
            st_d.lo = map_rdata;
        end
        if (phase == PH_HI) begin
            st_d.hi = map_rdata;
        end
        if (phase == PH_LOAD) begin
            // Shape byte arrives now; its leftmost pixel is output next.
            st_d.sreg  = shp_rdata << 1;
            st_d.color = shp_rdata[7] ? fg_color : bg_color;
            st_d.valid = 1'b1;
            st_d.px    = {x[XW-1:TILE_LG], {TILE_LG{1'b0}}};
            st_d.py    = y;
        end else begin
            st_d.sreg  = st_q.sreg << 1;
            st_d.color = st_q.sreg[7] ? fg_color : bg_color;
            st_d.px    = st_q.px + XW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shp_re    = (phase == PH_SHP);
    assign shp_addr  = {st_q.hi, st_q.lo, y[TILE_LG-1:0]};
    assign pix_valid = st_q.valid;
    assign pix_x     = st_q.px;
    assign pix_y     = st_q.py;
    assign pix_color = st_q.color;

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> pix_valid) // R2
        else $error("valid dropped");

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && $past(pix_x) != XW'(H_PIX - 1))
            |-> (pix_x == $past(pix_x) + XW'(1))) // R2
        else $error("column skipped");

    AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && $past(pix_x) == XW'(H_PIX - 1))
            |-> (pix_x == '0)) // R2
        else $error("column did not wrap");
endmodule

// File: rtl/tile_map_fetcher.sv
module tile_map_fetcher
    import tmf_pkg::*;
#(
    parameter int H_PIX   = 640,
    parameter int V_PIX   = 480,
    parameter int COLOR_W = 8,
    parameter int COLS    = H_PIX / TILE_PIX,
    parameter int ROWS    = V_PIX / TILE_PIX,
    parameter int MAP_AW  = $clog2(2 * COLS * ROWS),
    parameter int XW      = $clog2(H_PIX),
    parameter int YW      = $clog2(V_PIX)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [COLOR_W-1:0]       fg_color,
    input  logic [COLOR_W-1:0]       bg_color,
    input  logic                     cpu_req,
    input  logic [MAP_AW-1:0]        cpu_addr,
    input  logic [7:0]               cpu_data,
    output logic                     cpu_done,
    output logic                     map_re,
    output logic                     map_we,
    output logic [MAP_AW-1:0]        map_addr,
    output logic [7:0]               map_wdata,
    input  logic [7:0]               map_rdata,
    output logic                     shp_re,
    output logic [IDX_W+TILE_LG-1:0] shp_addr,
    input  logic [7:0]               shp_rdata,
    output logic                     pix_valid,
    output logic [XW-1:0]            pix_x,
    output logic [YW-1:0]            pix_y,
    output logic [COLOR_W-1:0]       pix_color
);
    logic [XW-1:0] scan_x;
    logic [YW-1:0] scan_y;

    tmf_scan #(
        .H_PIX (H_PIX),
        .V_PIX (V_PIX),
        .XW    (XW),
        .YW    (YW)
    ) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (scan_x),
        .y     (scan_y)
    );

    tmf_mapport #(
        .COLS   (COLS),
        .XW     (XW),
        .YW     (YW),
        .MAP_AW (MAP_AW)
    ) u_mapport (
        .clk       (clk),
        .rst_n     (rst_n),
        .x         (scan_x),
        .y         (scan_y),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_done  (cpu_done),
        .map_re    (map_re),
        .map_we    (map_we),
        .map_addr  (map_addr),
        .map_wdata (map_wdata)
    );

    tmf_pixel #(
        .H_PIX   (H_PIX),
        .XW      (XW),
        .YW      (YW),
        .COLOR_W (COLOR_W)
    ) u_pixel (
        .clk       (clk),
        .rst_n     (rst_n),
        .x         (scan_x),
        .y         (scan_y),
        .map_rdata (map_rdata),
        .shp_rdata (shp_rdata),
        .fg_color  (fg_color),
        .bg_color  (bg_color),
        .shp_re    (shp_re),
        .shp_addr  (shp_addr),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_color (pix_color)
    );

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> !map_re) // R6
        else $error("write in a display slot");

    AST_SHP_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        shp_re |-> $past(map_re, 2)) // R4
        else $error("shape read not two cycles after high-byte read");
endmodule

// File: tb/tile_map_fetcher_tb.sv
`timescale 1ns/1ps
module tile_map_fetcher_tb;
    localparam int H     = 64;
    localparam int V     = 24;
    localparam int COLS  = H / 8;
    localparam int ROWS  = V / 8;
    localparam int NBYTE = 2 * COLS * ROWS;
    localparam int AW    = $clog2(NBYTE);
    localparam int XW    = $clog2(H);
    localparam int YW    = $clog2(V);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      fg = 8'hC3;
    logic [7:0]      bg = 8'h1E;
    logic            cpu_req = 1'b0;
    logic [AW-1:0]   cpu_addr = '0;
    logic [7:0]      cpu_data = '0;
    logic            cpu_done;
    logic            map_re, map_we;
    logic [AW-1:0]   map_addr;
    logic [7:0]      map_wdata;
    logic [7:0]      map_rdata = '0;
    logic            shp_re;
    logic [18:0]     shp_addr;
    logic [7:0]      shp_rdata = '0;
    logic            pix_valid;
    logic [XW-1:0]   pix_x;
    logic [YW-1:0]   pix_y;
    logic [7:0]      pix_color;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_cnt = 0;
    bit finished = 0;

    logic [7:0] mem     [NBYTE];
    logic [7:0] exp_map [NBYTE];

    always #2.5 clk = ~clk;

    tile_map_fetcher #(.H_PIX(H), .V_PIX(V)) u_dut (
        .clk(clk), .rst_n(rst_n), .fg_color(fg), .bg_color(bg),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_done(cpu_done), .map_re(map_re), .map_we(map_we),
        .map_addr(map_addr), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .shp_re(shp_re), .shp_addr(shp_addr), .shp_rdata(shp_rdata),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .pix_color(pix_color)
    );

    function automatic logic [7:0] shp_fn(input logic [18:0] a);
        logic [18:0] t;
        t = a * 19'd53 + (a >> 7);
        return t[7:0] ^ t[15:8] ^ {5'd0, a[18:16]};
    endfunction

    function automatic logic [7:0] exp_color(input int px, input int py);
        int          ti;
        logic [15:0] idx;
        logic [7:0]  b;
        ti  = (py / 8) * COLS + px / 8;
        idx = {exp_map[2*ti+1], exp_map[2*ti]};
        b   = shp_fn({idx, 3'(py % 8)});
        return b[7 - (px % 8)] ? fg : bg;
    endfunction

    // Memory models: one-cycle read latency on both memories.
    always @(posedge clk) begin
        if (map_we) begin
            mem[map_addr] <= map_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (map_re) map_rdata <= mem[map_addr];
        if (shp_re) shp_rdata <= shp_fn(shp_addr);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", 32'(pix_valid), 0);
        check("R1", "we in reset", 32'(map_we), 0);
        check("R1", "done in reset", 32'(cpu_done), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            check("R1", "valid before first tile", 32'(pix_valid || cpu_done || map_we), 0);
            @(negedge clk);
        end
        check("R1", "valid at cycle 8", 32'(pix_valid), 1);
        check("R1", "first pixel x", 32'(pix_x), 0);
        check("R1", "first pixel y", 32'(pix_y), 0);
    endtask

    task automatic t_fetch_addr();
        int bad = 0;
        for (int n = 0; n < H * V; n++) begin
            int ph, fx, fy, ti;
            logic [18:0] ea;
            ph = cyc % 8;
            fx = cyc % H;
            fy = (cyc / H) % V;
            ti = (fy / 8) * COLS + fx / 8;
            if (ph % 4 == 0) begin
                if (!map_re || map_we || map_addr != AW'(2*ti + ph/4)) begin
                    if (bad == 0)
                        check("R3", "map read addr", {map_re, 3'd0, 28'(map_addr)},
                              {1'b1, 3'd0, 28'(2*ti + ph/4)});
                    bad++;
                end
            end else if (map_re) begin
                if (bad == 0) check("R3", "stray map read", 32'(map_re), 0);
                bad++;
            end
            if (ph == 6) begin
                ea = {exp_map[2*ti+1], exp_map[2*ti], 3'(fy % 8)};
                if (!shp_re || shp_addr != ea) begin
                    if (bad == 0) check("R4", "shape addr", 32'(shp_addr), 32'(ea));
                    bad++;
                end
            end else if (shp_re) begin
                if (bad == 0) check("R4", "stray shape read", 32'(shp_re), 0);
                bad++;
            end
            @(negedge clk);
        end
        if (bad == 0) begin
            check("R3", "map read schedule over a frame", 0, 0);
            check("R4", "shape read schedule over a frame", 0, 0);
        end
    endtask

    task automatic wait_sof();
        while (!(pix_valid && pix_x == 0 && pix_y == 0)) @(negedge clk);
    endtask

    task automatic t_frame(input string req);
        int bad_ord = 0;
        int bad_col = 0;
        wait_sof();
        @(negedge clk);
        wait_sof();
        for (int n = 0; n < H * V; n++) begin
            int ex, ey;
            logic [7:0] ec;
            ex = n % H;
            ey = n / H;
            if (!pix_valid || pix_x != XW'(ex) || pix_y != YW'(ey)) begin
                if (bad_ord == 0)
                    check("R2", "raster position", {16'(pix_y), 16'(pix_x)},
                          {16'(ey), 16'(ex)});
                bad_ord++;
            end
            ec = exp_color(ex, ey);
            if (pix_color != ec) begin
                if (bad_col == 0) check(req, "pixel colour", 32'(pix_color), 32'(ec));
                bad_col++;
            end
            @(negedge clk);
        end
        if (bad_ord == 0) check("R2", "raster order over a frame", 0, 0);
        if (bad_col == 0) check(req, "frame colours", 0, 0);
    endtask

    task automatic cpu_write(input int a, input logic [7:0] d);
        int wr0, seen_we;
        wr0 = wr_cnt;
        seen_we = 0;
        cpu_req  = 1'b1;
        cpu_addr = AW'(a);
        cpu_data = d;
        for (int n = 0; n < 20; n++) begin
            #1;
            if (cpu_done) break;
            if (map_we) begin
                seen_we++;
                check("R6", "write slot not a display slot", 32'(cyc % 4 != 0), 1);
                check("R6", "write addr", 32'(map_addr), 32'(a));
                check("R6", "write data", 32'(map_wdata), 32'(d));
            end
            @(negedge clk);
        end
        check("R7", "done seen after one write", {31'(seen_we), cpu_done}, {31'd1, 1'b1});
        check("R7", "no write in done cycle", 32'(map_we), 0);
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        check("R7", "done is one cycle", 32'(cpu_done), 0);
        check("R7", "writes per request", 32'(wr_cnt - wr0), 1);
        exp_map[a] = d;
    endtask

    task automatic t_cpu();
        cpu_write(0, 8'hA5);
        cpu_write(NBYTE - 1, 8'h07);
        cpu_write(13, 8'h5A);
        cpu_write(2 * 9 + 1, 8'hFF);
        t_frame("R8");
    endtask

    task automatic t_colors();
        @(negedge clk);
        fg = 8'h3C;
        bg = 8'hE1;
        @(negedge clk);
        check("R9", "colour after change", 32'(pix_color),
              32'(exp_color(int'(pix_x), int'(pix_y))));
        t_frame("R9");
    endtask

    initial begin
        for (int i = 0; i < NBYTE; i++) begin
            mem[i]     = 8'((i * 37 + 11) % 256);
            exp_map[i] = 8'((i * 37 + 11) % 256);
        end
        t_reset();
        t_fetch_addr();
        t_frame("R5");
        t_cpu();
        t_colors();
        summary();
    end
endmodule